// File: doc/BRIEF.md
# Operand Address Generation Unit

This unit forms the effective word address of a load/store operand for a small 32-bit processor whose memory is addressed in words. A start strobe presents the current instruction word. The unit takes a 2-bit addressing mode and a register index from fixed fields of that word. It reads the register file through a combinational read port and returns a 32-bit address together with a one-cycle valid strobe.

Two modes need the word that follows the instruction in the stream. In the absolute mode that word is the address. In the displacement mode it is an offset added to the register. For these modes the unit sends a one-cycle request to advance the program counter by one word and holds busy. It takes the trailing word on the extension-word input in the next cycle and delivers the address one cycle later than the register-only modes do.

Top module: `opnd_agu`

## Requirements
- R1: While rst_ni is low, addr_vld_o, busy_o and pc_inc_o are low and addr_o is zero.
- R2: Mode 0 (instruction bits [17:16] = 2'b00) returns the selected register's contents on addr_o with addr_vld_o high in the cycle after the start edge, with no PC request.
- R3: Mode 2 (bits [17:16] = 2'b10, register indirect) returns the selected register's contents as the address, with the same one-cycle timing and no PC request.
- R4: Mode 1 (bits [17:16] = 2'b01) raises pc_inc_o in the cycle after the start edge, samples ext_word_i in that cycle, and presents that word on addr_o with addr_vld_o one cycle later.
- R5: Mode 3 (bits [17:16] = 2'b11) follows the timing of R4. Its address is the register contents plus ext_word_i, taken modulo 2^32 with no overflow indication.
- R6: busy_o is high exactly in the single cycle between a fetch-mode start and its valid cycle, and is low at all other times.
- R7: pc_inc_o lasts one cycle and occurs exactly once per extension word. It never occurs for modes 0 and 2.
- R8: A start_i pulse while busy_o is high is ignored. It produces no extra PC request and no extra valid strobe.
- R9: The register index is instruction bits [12:8]. rf_raddr_o shows that index combinationally in the start cycle and holds it through the busy cycle.
- R10: A new start may be applied in the same cycle that addr_vld_o is high, and it is accepted.
- R11: With no start pending and busy_o low, the next cycle has addr_vld_o and pc_inc_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Instruction word present; begin address generation |
| instr_i | input | 32 | Current instruction word |
| rf_raddr_o | output | 5 | Register file read index |
| rf_rdata_i | input | 32 | Register file read data (combinational) |
| pc_inc_o | output | 1 | One-cycle request to advance the PC by one word |
| ext_word_i | input | 32 | Trailing instruction word, valid in the cycle pc_inc_o is high |
| busy_o | output | 1 | Waiting for the trailing word |
| addr_o | output | 32 | Effective address |
| addr_vld_o | output | 1 | addr_o is valid this cycle |

## Verification
Random instruction words spread over all four modes and all register indices. The random bits outside the decoded fields show that only the mode and index fields steer the result. Random register contents and trailing words keep each mode's result apart from the others: a register-only result cannot equal a fetched-word or sum result by accident. Directed cases cover a displacement sum that crosses 2^32 and a start applied during busy, which must leave no trace. They also cover a back-to-back start in the valid cycle, which must be taken up at once.

// File: rtl/opnd_agu_pkg.sv
package opnd_agu_pkg;
  typedef enum logic [1:0] {
    AM_REG  = 2'd0,
    AM_ABS  = 2'd1,
    AM_IND  = 2'd2,
    AM_DISP = 2'd3
  } amode_e;

  // modes with odd encoding consume a trailing instruction word
  function automatic logic needs_ext(amode_e m);
    return (m == AM_ABS) || (m == AM_DISP);
  endfunction
endpackage

// File: rtl/opnd_agu_ctrl.sv
module opnd_agu_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic need_ext_i,
  output logic accept_o,
  output logic done_o,
  output logic busy_o,
  output logic pc_inc_o
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_e;
  state_e state_q, state_d;
  logic   pc_inc_q;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign done_o   = (accept_o && !need_ext_i) || (state_q == ST_WAIT);
  assign busy_o   = (state_q == ST_WAIT);
  assign pc_inc_o = pc_inc_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_o && need_ext_i) state_d = ST_WAIT;
      ST_WAIT: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pc_inc_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      pc_inc_q <= accept_o && need_ext_i;
    end
  end
endmodule

// File: rtl/opnd_agu_calc.sv
module opnd_agu_calc
  import opnd_agu_pkg::*;
#(
  parameter int DW = 32
) (
  input  amode_e        mode_i,
  input  logic [DW-1:0] reg_i,
  input  logic [DW-1:0] ext_i,
  output logic [DW-1:0] addr_o
);
  logic [DW-1:0] sum;
  assign sum = reg_i + ext_i; // wraps modulo 2^DW

  always_comb begin
    unique case (mode_i)
      AM_REG, AM_IND: addr_o = reg_i;
      AM_ABS:         addr_o = ext_i;
      AM_DISP:        addr_o = sum;
      default:        addr_o = reg_i;
    endcase
  end
endmodule

// File: rtl/opnd_agu.sv
module opnd_agu
  import opnd_agu_pkg::*;
#(
  parameter int DW       = 32,
  parameter int IW       = 32,
  parameter int RAW      = 5,
  parameter int MODE_LSB = 16,
  parameter int RIDX_LSB = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [IW-1:0]  instr_i,
  output logic [RAW-1:0] rf_raddr_o,
  input  logic [DW-1:0]  rf_rdata_i,
  output logic           pc_inc_o,
  input  logic [DW-1:0]  ext_word_i,
  output logic           busy_o,
  output logic [DW-1:0]  addr_o,
  output logic           addr_vld_o
);
  localparam int MW = $bits(amode_e);

  amode_e        mode_in, mode_q, mode_sel;
  logic [RAW-1:0] ridx_in, ridx_q;
  logic          accept, done, busy;
  logic [DW-1:0] addr_d, addr_q;
  logic          vld_q;

  assign mode_in = amode_e'(instr_i[MODE_LSB +: MW]);
  assign ridx_in = instr_i[RIDX_LSB +: RAW];

  opnd_agu_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .need_ext_i(needs_ext(mode_in)),
    .accept_o  (accept),
    .done_o    (done),
    .busy_o    (busy),
    .pc_inc_o  (pc_inc_o)
  );

  // latch decoded fields while the trailing word is awaited
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= AM_REG;
      ridx_q <= '0;
    end else if (accept) begin
      mode_q <= mode_in;
      ridx_q <= ridx_in;
    end
  end

  assign mode_sel   = busy ? mode_q : mode_in;
  assign rf_raddr_o = busy ? ridx_q : ridx_in;

  opnd_agu_calc #(.DW(DW)) u_calc (
    .mode_i(mode_sel),
    .reg_i (rf_rdata_i),
    .ext_i (ext_word_i),
    .addr_o(addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= done;
      if (done) addr_q <= addr_d;
    end
  end

  assign addr_o     = addr_q;
  assign addr_vld_o = vld_q;
  assign busy_o     = busy;
endmodule

// File: rtl/opnd_agu_chk.sv
module opnd_agu_chk #(
  parameter int IW       = 32,
  parameter int MODE_LSB = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [IW-1:0] instr_i,
  input logic          busy_o,
  input logic          pc_inc_o,
  input logic          addr_vld_o
);
  AST_DIRECT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && !instr_i[MODE_LSB] |=> addr_vld_o && !busy_o && !pc_inc_o); // R2
  AST_FETCH_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && instr_i[MODE_LSB] |=> pc_inc_o && busy_o && !addr_vld_o); // R4
  AST_BUSY_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> addr_vld_o && !busy_o); // R6
  AST_PC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_inc_o |=> !pc_inc_o); // R7
  AST_PC_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_inc_o |-> busy_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && !busy_o |=> !addr_vld_o && !pc_inc_o); // R11
endmodule

bind opnd_agu opnd_agu_chk #(.IW(IW), .MODE_LSB(MODE_LSB)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .instr_i   (instr_i),
  .busy_o    (busy_o),
  .pc_inc_o  (pc_inc_o),
  .addr_vld_o(addr_vld_o)
);

// File: tb/opnd_agu_tb.sv
module opnd_agu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [4:0]  raddr;
  logic [31:0] rdata;
  logic        pc_inc;
  logic [31:0] ext = '0;
  logic        busy;
  logic [31:0] addr;
  logic        vld;
  logic [31:0] rf_mem [32];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  assign rdata = rf_mem[raddr];

  opnd_agu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .instr_i(instr),
    .rf_raddr_o(raddr), .rf_rdata_i(rdata), .pc_inc_o(pc_inc),
    .ext_word_i(ext), .busy_o(busy), .addr_o(addr), .addr_vld_o(vld)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_instr(logic [1:0] m, logic [4:0] r);
    logic [31:0] w = $urandom;
    w[17:16] = m;
    w[12:8]  = r;
    return w;
  endfunction

  function automatic logic [31:0] exp_addr(logic [1:0] m, logic [31:0] rv, logic [31:0] e);
    case (m)
      2'd1:    return e;
      2'd3:    return rv + e;
      default: return rv;
    endcase
  endfunction

  task automatic run_op(logic [1:0] m, logic [4:0] r, logic [31:0] e, bit junk);
    @(negedge clk);
    instr = mk_instr(m, r);
    start = 1'b1;
    #1 chk("R9 raddr in start cycle", {27'd0, raddr}, {27'd0, r});
    @(negedge clk);
    start = 1'b0;
    ext   = e;
    if (m[0]) begin
      chk("R4/R7 pc_inc pulse", {31'd0, pc_inc}, 32'd1);
      chk("R6 busy during fetch", {31'd0, busy}, 32'd1);
      chk("R6 no valid while busy", {31'd0, vld}, 32'd0);
      chk("R9 raddr held", {27'd0, raddr}, {27'd0, r});
      if (junk) begin
        instr = mk_instr(2'd1, r + 5'd1);
        start = 1'b1; // R8 must be ignored
      end
      @(negedge clk);
      start = 1'b0;
      ext   = $urandom;
      chk(m == 2'd3 ? "R5 disp addr" : "R4 abs addr", addr, exp_addr(m, rf_mem[r], e));
      chk("R4 valid after fetch", {31'd0, vld}, 32'd1);
      chk("R7 pc_inc single", {31'd0, pc_inc}, 32'd0);
      chk("R6 busy cleared", {31'd0, busy}, 32'd0);
    end else begin
      chk(m == 2'd0 ? "R2 reg addr" : "R3 indirect addr", addr, rf_mem[r]);
      chk("R2 valid next cycle", {31'd0, vld}, 32'd1);
      chk("R7 no pc_inc direct mode", {31'd0, pc_inc}, 32'd0);
      chk("R6 no busy direct mode", {31'd0, busy}, 32'd0);
    end
    @(negedge clk);
    chk("R11/R8 idle no valid", {31'd0, vld}, 32'd0);
    chk("R11/R8 idle no pc_inc", {31'd0, pc_inc}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) rf_mem[i] = $urandom;
    rf_mem[5] = 32'hFFFF_FFF0;
    @(negedge clk);
    #1;
    chk("R1 reset valid", {31'd0, vld}, 32'd0);
    chk("R1 reset busy", {31'd0, busy}, 32'd0);
    chk("R1 reset pc_inc", {31'd0, pc_inc}, 32'd0);
    chk("R1 reset addr", addr, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed corners
    run_op(2'd0, 5'd3, 32'h0, 1'b0);
    run_op(2'd2, 5'd31, 32'h0, 1'b0);
    run_op(2'd1, 5'd7, 32'hDEAD_BEEF, 1'b0);
    run_op(2'd3, 5'd5, 32'h0000_0020, 1'b0); // R5 wrap to 0x10
    run_op(2'd3, 5'd9, 32'h1234_5678, 1'b1); // R8 start during busy
    run_op(2'd1, 5'd0, 32'h0000_0001, 1'b1);

    // R10 back-to-back start in the valid cycle
    @(negedge clk);
    instr = mk_instr(2'd0, 5'd1);
    start = 1'b1;
    @(negedge clk);
    chk("R10 first addr", addr, rf_mem[1]);
    instr = mk_instr(2'd3, 5'd2);
    @(negedge clk);
    start = 1'b0;
    ext   = 32'h0000_0100;
    chk("R10 second start accepted", {31'd0, pc_inc}, 32'd1);
    @(negedge clk);
    chk("R10 second addr", addr, rf_mem[2] + 32'h0000_0100);
    chk("R10 second valid", {31'd0, vld}, 32'd1);

    // random mix
    for (int k = 0; k < 300; k++) begin
      logic [1:0] m = 2'($urandom);
      logic [4:0] r = 5'($urandom);
      run_op(m, r, $urandom, bit'($urandom));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule